// File: doc/BRIEF.md
# Received Frame Queue with Level Interrupt

This block holds incoming network frames in a small circular queue until the host consumes them. Frames arrive one byte per cycle on a receive stream whose final byte is flagged. Each frame is written into a fixed-size slot together with its stored length. Bytes beyond the slot size are dropped. A frame that begins while every slot is occupied is discarded in full.

The host works through a single command port. A receive command pops the oldest frame and reports its slot and length. The host then fetches the frame bytes through a registered read port. Other commands report the occupancy, empty the queue, load the interrupt enable, raise the interrupt unconditionally, or do nothing.

The queue keeps no read pointer. The oldest slot is always derived from the write slot and the occupancy. The interrupt output is a level. Frame arrival raises it when enabled, the mask command re-evaluates it, and a receive that empties the queue lowers it.

Top module: `rx_frame_ring`

## Requirements
- R1: A frame is committed on the cycle its byte with `rx_last` is accepted. It is stored in the slot at the write index, the write index advances by one modulo DEPTH (slots 0,1,2,3,0,...), and the occupancy grows by one.
- R2: When a frame's first byte arrives while the occupancy equals DEPTH, the whole frame is discarded and the occupancy, slots and lengths are left unchanged.
- R3: A frame longer than BUF_BYTES keeps only its first BUF_BYTES bytes, and its recorded length is BUF_BYTES.
- R4: Command op 3'd1 (receive) on a non-empty queue reports `rsp_slot` = (write index − occupancy + DEPTH) mod DEPTH and `rsp_len` = the length stored there. It then lowers the occupancy by one, so frames come out oldest first.
- R5: Op 3'd1 on an empty queue answers with `rsp_ok`=1 and `rsp_len`=0, and the occupancy stays at zero.
- R6: When op 3'd1 leaves the occupancy at zero, `irq` is low on the next cycle.
- R7: A committed frame drives `irq` high on the next cycle when the enable is set. With the enable clear, an arrival does not change `irq`.
- R8: Op 3'd4 (mask) sets the enable to (`cmd_arg` != 0). `irq` then becomes enable AND (occupancy > 0).
- R9: Op 3'd3 (flush) sets the occupancy to zero. It leaves `irq` and the write index unchanged, so the next frame lands in the following slot.
- R10: Op 3'd5 (force) drives `irq` high on the next cycle, whatever the enable and the occupancy.
- R11: Op 3'd2 (length query) answers with `rsp_qlen` = the occupancy and `rsp_len` = 2. All other ops answer with `rsp_qlen` = 0.
- R12: Every command is answered with `rsp_valid` exactly one cycle later. Ops 3'd0 to 3'd5 give `rsp_ok`=1 and ops 3'd6 and 3'd7 give `rsp_ok`=0. `rd_data` holds the byte at (`rd_slot`, `rd_addr`) one cycle after the address is presented.
- R13: When a frame commit and a receive of a non-empty queue happen in the same cycle, both take effect. The receive returns the previous oldest entry and the occupancy is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_valid | input | 1 | Receive byte present |
| rx_data | input | 8 | Receive byte |
| rx_last | input | 1 | Final byte of the frame |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 3 | Command code (see R4 to R12) |
| cmd_arg | input | 8 | Command data byte (enable for mask) |
| rsp_valid | output | 1 | Response strobe |
| rsp_ok | output | 1 | Command code recognised |
| rsp_len | output | LEN_W | Output length of the response |
| rsp_slot | output | IDX_W | Slot holding the frame returned by receive |
| rsp_qlen | output | 16 | Occupancy reported by the length query |
| rd_slot | input | IDX_W | Byte read slot |
| rd_addr | input | ADDR_W | Byte read offset |
| rd_data | output | 8 | Registered read byte |
| irq | output | 1 | Level interrupt |

## Verification
Command answers, occupancy changes and interrupt changes are all due one clock after the command or the final frame byte is sampled. Read bytes are due one clock after their address. The bench drives every input on a falling edge and records the expected answer at the moment it drives a command. A monitor then compares each answer on the next falling edge, one full register stage later. Interrupt levels and read bytes are sampled on the falling edge that follows the edge doing the update. The case where a commit and a receive fall on the same edge is arranged by issuing the command together with the last frame byte.

// File: rtl/rxr_pkg.sv
package rxr_pkg;
   typedef enum logic [2:0] {
      OP_IDLE  = 3'd0,
      OP_RECV  = 3'd1,
      OP_QLEN  = 3'd2,
      OP_FLUSH = 3'd3,
      OP_MASK  = 3'd4,
      OP_FORCE = 3'd5
   } rxr_op_e;
endpackage

// File: rtl/rxr_frame_writer.sv
module rxr_frame_writer #(
   parameter int BUF_BYTES = 16,
   parameter int LEN_W     = 5,
   parameter int ADDR_W    = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rx_valid,
   input  logic              rx_last,
   input  logic              full,
   output logic              byte_we,
   output logic [ADDR_W-1:0] byte_addr,
   output logic              commit,
   output logic [LEN_W-1:0]  commit_len
);
   localparam logic [LEN_W-1:0] BUF_L = LEN_W'(BUF_BYTES);

   logic             in_frame_q, drop_q;
   logic [LEN_W-1:0] pos_q;
   logic             start, keep, room;
   logic [LEN_W-1:0] pos, pos_n;

   always_comb begin
      start      = rx_valid && !in_frame_q;
      keep       = start ? !full : !drop_q;
      pos        = start ? '0 : pos_q;
      room       = pos < BUF_L;
      pos_n      = room ? pos + LEN_W'(1) : pos;
      byte_we    = rx_valid && keep && room;
      byte_addr  = pos[ADDR_W-1:0];
      commit     = rx_valid && rx_last && keep;
      commit_len = pos_n;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         in_frame_q <= 1'b0;
         drop_q     <= 1'b0;
         pos_q      <= '0;
      end else if (rx_valid) begin
         if (rx_last) begin
            in_frame_q <= 1'b0;
            drop_q     <= 1'b0;
            pos_q      <= '0;
         end else begin
            in_frame_q <= 1'b1;
            drop_q     <= !keep;
            pos_q      <= pos_n;
         end
      end
   end
endmodule

// File: rtl/rxr_slot_store.sv
module rxr_slot_store #(
   parameter int DEPTH     = 4,
   parameter int BUF_BYTES = 16,
   parameter int IDX_W     = 2,
   parameter int LEN_W     = 5,
   parameter int ADDR_W    = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              byte_we,
   input  logic [IDX_W-1:0]  w_slot,
   input  logic [ADDR_W-1:0] w_addr,
   input  logic [7:0]        w_data,
   input  logic              len_we,
   input  logic [LEN_W-1:0]  len_val,
   input  logic [IDX_W-1:0]  lk_slot,
   output logic [LEN_W-1:0]  lk_len,
   input  logic [IDX_W-1:0]  rd_slot,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [7:0]        rd_data
);
   logic [7:0]       bank_rd  [DEPTH];
   logic [LEN_W-1:0] bank_len [DEPTH];

   for (genvar s = 0; s < DEPTH; s++) begin : g_bank
      logic [7:0]       bytes_q [BUF_BYTES];
      logic [LEN_W-1:0] len_q;
      logic             sel;

      assign sel = (w_slot == IDX_W'(s));

      always_ff @(posedge clk) begin
         if (byte_we && sel) bytes_q[w_addr] <= w_data;
      end

      always_ff @(posedge clk) begin
         if (!rst_n)            len_q <= '0;
         else if (len_we && sel) len_q <= len_val;
      end

      assign bank_rd[s]  = bytes_q[rd_addr];
      assign bank_len[s] = len_q;
   end

   assign lk_len = bank_len[lk_slot];

   always_ff @(posedge clk) begin
      if (!rst_n) rd_data <= '0;
      else        rd_data <= bank_rd[rd_slot];
   end
endmodule

// File: rtl/rxr_queue_ctrl.sv
module rxr_queue_ctrl import rxr_pkg::*; #(
   parameter int DEPTH = 4,
   parameter int IDX_W = 2,
   parameter int CNT_W = 3,
   parameter int LEN_W = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             commit,
   input  logic             cmd_valid,
   input  logic [2:0]       cmd_op,
   input  logic [7:0]       cmd_arg,
   input  logic [LEN_W-1:0] lk_len,
   output logic [IDX_W-1:0] wr_idx,
   output logic [IDX_W-1:0] oldest,
   output logic [CNT_W-1:0] count,
   output logic             full,
   output logic             irq,
   output logic             rsp_valid,
   output logic             rsp_ok,
   output logic [LEN_W-1:0] rsp_len,
   output logic [IDX_W-1:0] rsp_slot,
   output logic [15:0]      rsp_qlen
);
   localparam bit POW2 = (DEPTH & (DEPTH - 1)) == 0;

   logic             en_q;
   logic             is_recv, is_qlen, is_flush, is_mask, is_force, known, pop;
   logic [CNT_W-1:0] cnt_n;
   logic [IDX_W-1:0] wr_inc;
   logic             en_n, irq_n;

   if (POW2) begin : g_mask_wrap
      assign oldest = wr_idx - IDX_W'(count);
      assign wr_inc = wr_idx + IDX_W'(1);
   end else begin : g_mod_wrap
      assign oldest = IDX_W'((int'(wr_idx) + DEPTH - int'(count)) % DEPTH);
      assign wr_inc = (wr_idx == IDX_W'(DEPTH - 1)) ? '0 : wr_idx + IDX_W'(1);
   end

   assign full = (count == CNT_W'(DEPTH));

   always_comb begin
      is_recv  = cmd_valid && (cmd_op == OP_RECV);
      is_qlen  = cmd_valid && (cmd_op == OP_QLEN);
      is_flush = cmd_valid && (cmd_op == OP_FLUSH);
      is_mask  = cmd_valid && (cmd_op == OP_MASK);
      is_force = cmd_valid && (cmd_op == OP_FORCE);
      known    = cmd_op <= OP_FORCE;
      pop      = is_recv && (count != '0);

      cnt_n = is_flush ? '0 : count - CNT_W'(pop);
      cnt_n = cnt_n + CNT_W'(commit);

      en_n  = is_mask ? (cmd_arg != 8'd0) : en_q;

      irq_n = irq;
      if (is_force)                     irq_n = 1'b1;
      if (is_mask)                      irq_n = en_n && (cnt_n != '0);
      if (is_recv && (cnt_n == '0))     irq_n = 1'b0;
      if (commit && en_n)               irq_n = 1'b1;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         count  <= '0;
         wr_idx <= '0;
         en_q   <= 1'b0;
         irq    <= 1'b0;
      end else begin
         count  <= cnt_n;
         wr_idx <= commit ? wr_inc : wr_idx;
         en_q   <= en_n;
         irq    <= irq_n;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rsp_valid <= 1'b0;
         rsp_ok    <= 1'b0;
         rsp_len   <= '0;
         rsp_slot  <= '0;
         rsp_qlen  <= '0;
      end else begin
         rsp_valid <= cmd_valid;
         rsp_ok    <= cmd_valid && known;
         rsp_slot  <= oldest;
         rsp_qlen  <= is_qlen ? 16'(count) : 16'd0;
         if (pop)          rsp_len <= lk_len;
         else if (is_qlen) rsp_len <= LEN_W'(2);
         else              rsp_len <= '0;
      end
   end
endmodule

// File: rtl/rx_frame_ring.sv
module rx_frame_ring #(
   parameter  int DEPTH     = 4,
   parameter  int BUF_BYTES = 16,
   localparam int IDX_W     = (DEPTH > 1) ? $clog2(DEPTH) : 1,
   localparam int CNT_W     = $clog2(DEPTH + 1),
   localparam int LEN_W     = $clog2(BUF_BYTES + 1),
   localparam int ADDR_W    = (BUF_BYTES > 1) ? $clog2(BUF_BYTES) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rx_valid,
   input  logic [7:0]        rx_data,
   input  logic              rx_last,
   input  logic              cmd_valid,
   input  logic [2:0]        cmd_op,
   input  logic [7:0]        cmd_arg,
   output logic              rsp_valid,
   output logic              rsp_ok,
   output logic [LEN_W-1:0]  rsp_len,
   output logic [IDX_W-1:0]  rsp_slot,
   output logic [15:0]       rsp_qlen,
   input  logic [IDX_W-1:0]  rd_slot,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [7:0]        rd_data,
   output logic              irq
);
   initial begin : chk_params
      assert (DEPTH >= 2) else $fatal(1, "DEPTH must be at least 2");
      assert (BUF_BYTES >= 2) else $fatal(1, "BUF_BYTES must be at least 2");
      assert (DEPTH < 65536) else $fatal(1, "DEPTH must fit the 16-bit length answer");
   end

   logic              q_commit, q_full, byte_we;
   logic [ADDR_W-1:0] byte_addr;
   logic [LEN_W-1:0]  commit_len, lk_len;
   logic [IDX_W-1:0]  wr_idx, oldest;
   logic [CNT_W-1:0]  q_count;

   rxr_frame_writer #(.BUF_BYTES(BUF_BYTES), .LEN_W(LEN_W), .ADDR_W(ADDR_W)) u_writer (
      .clk, .rst_n, .rx_valid, .rx_last,
      .full(q_full), .byte_we, .byte_addr,
      .commit(q_commit), .commit_len
   );

   rxr_slot_store #(.DEPTH(DEPTH), .BUF_BYTES(BUF_BYTES), .IDX_W(IDX_W),
                    .LEN_W(LEN_W), .ADDR_W(ADDR_W)) u_store (
      .clk, .rst_n,
      .byte_we, .w_slot(wr_idx), .w_addr(byte_addr), .w_data(rx_data),
      .len_we(q_commit), .len_val(commit_len),
      .lk_slot(oldest), .lk_len,
      .rd_slot, .rd_addr, .rd_data
   );

   rxr_queue_ctrl #(.DEPTH(DEPTH), .IDX_W(IDX_W), .CNT_W(CNT_W), .LEN_W(LEN_W)) u_ctrl (
      .clk, .rst_n, .commit(q_commit),
      .cmd_valid, .cmd_op, .cmd_arg, .lk_len,
      .wr_idx, .oldest, .count(q_count), .full(q_full), .irq,
      .rsp_valid, .rsp_ok, .rsp_len, .rsp_slot, .rsp_qlen
   );
endmodule

// File: rtl/rx_frame_ring_chk.sv
module rx_frame_ring_chk #(
   parameter int DEPTH = 4,
   parameter int CNT_W = 3,
   parameter int LEN_W = 5
) (
   input logic             clk,
   input logic             rst_n,
   input logic             cmd_valid,
   input logic [2:0]       cmd_op,
   input logic [7:0]       cmd_arg,
   input logic             rsp_valid,
   input logic [LEN_W-1:0] rsp_len,
   input logic [15:0]      rsp_qlen,
   input logic             irq,
   input logic [CNT_W-1:0] q_count,
   input logic             q_commit
);
   p_count_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
      q_count <= CNT_W'(DEPTH));

   p_full_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (q_count == CNT_W'(DEPTH) && !cmd_valid) |=> (q_count == CNT_W'(DEPTH)));

   p_empty_recv_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && cmd_op == 3'd1 && q_count == '0) |=> (rsp_len == '0));

   p_mask_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && cmd_op == 3'd4 && cmd_arg == 8'd0) |=> !irq);

   p_force_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && cmd_op == 3'd5) |=> irq);

   p_qlen_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && cmd_op == 3'd2) |=> (rsp_qlen == 16'($past(q_count)) && rsp_len == LEN_W'(2)));

   p_rsp_due_r12: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid |=> rsp_valid);

   p_rsp_quiet_r12: assert property (@(posedge clk) disable iff (!rst_n)
      !cmd_valid |=> !rsp_valid);

   p_overlap_r13: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && cmd_op == 3'd1 && q_count != '0 && q_commit) |=> $stable(q_count));
endmodule

bind rx_frame_ring rx_frame_ring_chk #(.DEPTH(DEPTH), .CNT_W(CNT_W), .LEN_W(LEN_W)) u_chk (
   .clk, .rst_n, .cmd_valid, .cmd_op, .cmd_arg,
   .rsp_valid, .rsp_len, .rsp_qlen, .irq, .q_count, .q_commit
);

// File: tb/rx_frame_ring_test.sv
`timescale 1ns/1ps
module rx_frame_ring_test;
   localparam int DEPTH = 4;
   localparam int BUFB  = 16;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       rx_valid = 1'b0, rx_last = 1'b0;
   logic [7:0] rx_data = '0;
   logic       cmd_valid = 1'b0;
   logic [2:0] cmd_op = '0;
   logic [7:0] cmd_arg = '0;
   logic       rsp_valid, rsp_ok;
   logic [4:0] rsp_len;
   logic [1:0] rsp_slot;
   logic [15:0] rsp_qlen;
   logic [1:0] rd_slot = '0;
   logic [3:0] rd_addr = '0;
   logic [7:0] rd_data;
   logic       irq;

   always #4 clk = ~clk;

   rx_frame_ring #(.DEPTH(DEPTH), .BUF_BYTES(BUFB)) uut (
      .clk, .rst_n, .rx_valid, .rx_data, .rx_last,
      .cmd_valid, .cmd_op, .cmd_arg,
      .rsp_valid, .rsp_ok, .rsp_len, .rsp_slot, .rsp_qlen,
      .rd_slot, .rd_addr, .rd_data, .irq
   );

   int n_total = 0, n_bad = 0;
   int m_cnt = 0, m_wr = 0, m_en = 0, m_irq = 0;
   int m_len [DEPTH];
   int m_mem [DEPTH][BUFB];
   int last_slot = 0, last_len = 0;

   int    q_ok[$], q_len[$], q_slot[$], q_qlen[$];
   string q_req[$];

   task automatic chk(input string req, input int act, input int exp);
      n_total++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic expect_rsp(input int ok, input int len, input int slot, input int qlen,
                             input string req);
      q_ok.push_back(ok); q_len.push_back(len); q_slot.push_back(slot);
      q_qlen.push_back(qlen); q_req.push_back(req);
   endtask

   // requirement model of one command; with_commit marks a frame committing on the same edge
   task automatic model_cmd(input int op, input int arg, input bit with_commit, input string req);
      int slot;
      case (op)
         1: begin
            slot = (m_wr - m_cnt + DEPTH) % DEPTH;
            last_slot = slot;
            if (m_cnt > 0) begin
               last_len = m_len[slot];
               m_cnt--;
            end else last_len = 0;
            expect_rsp(1, last_len, slot, 0, req);
            if (m_cnt == 0 && !with_commit) m_irq = 0;
         end
         2: expect_rsp(1, 2, -1, m_cnt, req);
         3: begin m_cnt = 0; expect_rsp(1, 0, -1, 0, req); end
         4: begin
            m_en  = (arg != 0);
            m_irq = (m_en != 0 && m_cnt > 0) ? 1 : 0;
            expect_rsp(1, 0, -1, 0, req);
         end
         5: begin m_irq = 1; expect_rsp(1, 0, -1, 0, req); end
         0: expect_rsp(1, 0, -1, 0, req);
         default: expect_rsp(0, 0, -1, 0, req);
      endcase
   endtask

   task automatic cmd(input int op, input int arg, input string req);
      @(negedge clk);
      cmd_valid = 1'b1; cmd_op = 3'(op); cmd_arg = 8'(arg);
      model_cmd(op, arg, 1'b0, req);
      @(negedge clk);
      cmd_valid = 1'b0;
   endtask

   task automatic frame(input int n, input int seed, input bit with_recv);
      bit was_full;
      was_full = (m_cnt == DEPTH);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         rx_valid = 1'b1; rx_data = 8'(seed + i); rx_last = (i == n - 1);
         if (i == n - 1 && with_recv) begin
            cmd_valid = 1'b1; cmd_op = 3'd1; cmd_arg = 8'd0;
            model_cmd(1, 0, !was_full, "R13");
         end
      end
      @(negedge clk);
      rx_valid = 1'b0; rx_last = 1'b0; cmd_valid = 1'b0;
      if (!was_full) begin
         m_len[m_wr] = (n > BUFB) ? BUFB : n;
         for (int i = 0; i < BUFB && i < n; i++) m_mem[m_wr][i] = (seed + i) & 8'hFF;
         m_wr = (m_wr + 1) % DEPTH;
         m_cnt++;
         if (m_en != 0) m_irq = 1;
      end
   endtask

   task automatic read_frame(input int slot, input int len, input string req);
      for (int i = 0; i < len; i++) begin
         @(negedge clk);
         rd_slot = 2'(slot); rd_addr = 4'(i);
         @(negedge clk);
         chk(req, int'(rd_data), m_mem[slot][i]);
      end
   endtask

   // scoreboard monitor: answers are due one edge after the command
   always @(negedge clk) begin
      string r;
      int es;
      if (rst_n && rsp_valid) begin
         if (q_ok.size() == 0) chk("R12 unexpected response", 1, 0);
         else begin
            r  = q_req.pop_front();
            es = q_slot.pop_front();
            chk({r, " ok"},   int'(rsp_ok),   q_ok.pop_front());
            chk({r, " len"},  int'(rsp_len),  q_len.pop_front());
            chk({r, " qlen"}, int'(rsp_qlen), q_qlen.pop_front());
            if (es >= 0) chk({r, " slot"}, int'(rsp_slot), es);
         end
      end
   end

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      n_total++; n_bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", n_total, n_bad);
      $finish;
   end

   initial begin : main
      repeat (3) @(negedge clk);
      chk("R12 reset rsp_valid", int'(rsp_valid), 0);
      chk("R8 reset irq", int'(irq), 0);
      rst_n = 1'b1;

      cmd(2, 0, "R11 empty query");                 // occupancy 0
      cmd(1, 0, "R5 empty receive");                // len 0, slot 0
      chk("R5 irq after empty receive", int'(irq), 0);

      frame(5, 8'h10, 1'b0);                        // slot 0, enable clear
      chk("R7 disabled arrival keeps irq low", int'(irq), 0);
      cmd(2, 0, "R1 one stored");

      cmd(4, 1, "R8 enable");
      chk("R8 enable with frame raises irq", int'(irq), 1);
      cmd(4, 0, "R8 disable");
      chk("R8 disable lowers irq", int'(irq), 0);
      cmd(4, 8'h80, "R8 nonzero byte enables");
      chk("R8 high bit enables", int'(irq), 1);

      frame(3, 8'h20, 1'b0);                        // slot 1
      frame(16, 8'h40, 1'b0);                       // slot 2, exactly full size
      frame(20, 8'h60, 1'b0);                       // slot 3, truncated to 16
      cmd(2, 0, "R1 queue full");                   // 4
      frame(7, 8'h80, 1'b0);                        // dropped
      cmd(2, 0, "R2 drop keeps occupancy");         // still 4

      cmd(1, 0, "R4 oldest first");                 // slot 0 len 5
      read_frame(last_slot, last_len, "R4 bytes slot0");
      chk("R6 irq stays with frames left", int'(irq), 1);
      cmd(1, 0, "R4 second");                       // slot 1 len 3
      read_frame(last_slot, last_len, "R12 read latency slot1");
      cmd(1, 0, "R3 full-size frame");              // slot 2 len 16
      cmd(1, 0, "R3 truncated frame");              // slot 3 len 16
      read_frame(last_slot, last_len, "R3 truncated bytes");
      chk("R6 last receive lowers irq", int'(irq), 0);

      frame(2, 8'h90, 1'b0);                        // wraps to slot 0
      chk("R7 enabled arrival raises irq", int'(irq), 1);
      cmd(3, 0, "R9 flush");
      chk("R9 flush leaves irq", int'(irq), 1);
      cmd(2, 0, "R9 flush empties");                // 0
      cmd(1, 0, "R9 receive after flush");          // len 0, slot 1
      chk("R6 empty receive lowers irq", int'(irq), 0);

      cmd(4, 0, "R8 disable again");
      cmd(5, 0, "R10 force");
      chk("R10 force raises irq when disabled and empty", int'(irq), 1);
      cmd(7, 0, "R12 unknown op");
      cmd(0, 0, "R12 idle op");
      chk("R12 idle op keeps irq", int'(irq), 1);
      cmd(4, 1, "R8 enable on empty");
      chk("R8 enable on empty lowers irq", int'(irq), 0);

      frame(4, 8'hA0, 1'b0);                        // slot 1 after flush
      frame(6, 8'hB0, 1'b1);                        // slot 2, receive of slot 1 same edge
      cmd(2, 0, "R13 occupancy unchanged");         // 1
      read_frame(last_slot, last_len, "R13 popped bytes");
      cmd(1, 0, "R13 later receive");               // slot 2 len 6
      read_frame(last_slot, last_len, "R1 slot after flush bytes");
      chk("R6 irq low after drain", int'(irq), 0);

      repeat (2) @(negedge clk);
      chk("R12 all answers seen", q_ok.size(), 0);
      $display("test done: total=%0d bad=%0d", n_total, n_bad);
      $finish;
   end
endmodule